// File: doc/BRIEF.md
# Caller-ID Receiver Host Interface

This block is the digital control side of a caller-ID receiver. It sits between the already-digital detector flags (demodulated bytes, CAS tone, CPM tone, FSK energy, ring, line reversal, hook state) and a host processor. Two mode pins and a power-down input choose how the block behaves. The `mode_cas` pin picks CAS mode when high and FSK/CPM mode when low. The `mode_wake` pin picks the wake/hook variant.

The host talks to the block over one serial port. The serial clock is active-low. A write-data line loads an 8-bit control register while in CAS mode. A read-data line shifts out received FSK bytes while in FSK mode. Three active-low indications report events to the host: interrupt, detect and ring/hook. What each indication means depends on the mode pins and on power-down.

The mode pins, the serial clock and the write-data line each pass through a two-flop synchroniser into the system clock. Serial clock edges are detected after synchronisation. The detector flags and `pwr_down` are taken as already synchronous to `clk`. Every indication and the read-data line come out of a register.

Top module: `cid_host_if`

## Requirements
- R1: While `rst_n` is low, `irq_n`, `det_n`, `ring_hook_n` and `ser_dout` are all 1. Reset also returns the control register to 0x00, which leaves the CPM select bit cleared.
- R2: A control write counts only after `mode_cas` has been seen low at least once since reset. Before that, writes are ignored. Taking `mode_cas` low also clears the write bit counter, so a partly shifted write is discarded.
- R3: A write in CAS mode (`mode_cas` high) takes 8 bits, most significant bit first. Each bit is sampled on a rising edge of `ser_clk_n`, and the byte is committed after the eighth bit. Bit 0 of the control register selects CPM (1) or FSK (0) whenever `mode_cas` is low.
- R4: In FSK mode, a `rx_valid` pulse loads `rx_data` and drives `irq_n` low. `irq_n` goes back high after the first rising edge of `ser_clk_n`, which marks the first bit as read.
- R5: In FSK mode, the loaded byte appears on `ser_dout` most significant bit first. The line takes a new bit at each falling edge of `ser_clk_n`.
- R6: `ser_dout` is held at 1 in power-down, in CAS mode and in CPM mode.
- R7: Outside power-down, `irq_n` follows the inverse of `cas_tone` in CAS mode and the inverse of `cpm_tone` in CPM mode.
- R8: In power-down, `irq_n` is low exactly when `ring_det` or `line_rev` is high.
- R9: In power-down, `det_n` is low on ring or line reversal when `mode_wake` is 0. It is low on ring or FSK energy when `mode_wake` is 1.
- R10: Outside power-down, `det_n` is low while `cas_tone` is high (CAS mode), `cpm_tone` is high (CPM mode) or `fsk_energy` is high (FSK mode).
- R11: `ring_hook_n` is the inverse of `ring_det` when `mode_wake` is 0. When `mode_wake` is 1 it equals `on_hook`: 1 means on-hook and 0 means off-hook.
- R12: A `rx_valid` pulse that arrives outside FSK mode is ignored. It raises no interrupt after FSK mode is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_cas | input | 1 | High: CAS mode and writes; low: FSK/CPM mode and reads |
| mode_wake | input | 1 | Wake/hook variant select |
| pwr_down | input | 1 | Power-down request |
| ser_clk_n | input | 1 | Host serial clock, active-low, idles high |
| ser_din | input | 1 | Host write data |
| rx_data | input | DATA_W | Demodulated FSK byte |
| rx_valid | input | 1 | One-cycle strobe for `rx_data` |
| cas_tone | input | 1 | CAS tone present |
| cpm_tone | input | 1 | CPM tone present |
| fsk_energy | input | 1 | FSK energy present |
| ring_det | input | 1 | Ring detected |
| line_rev | input | 1 | Line reversal detected |
| on_hook | input | 1 | Hook state, 1 = on-hook |
| ser_dout | output | 1 | Host read data |
| irq_n | output | 1 | Interrupt, active-low |
| det_n | output | 1 | Detect indication, active-low |
| ring_hook_n | output | 1 | Ring or hook indication |

## Verification
The assertions assume that the detector flags and `pwr_down` are already synchronous to `clk`. They also assume that the host changes `ser_din` only while `ser_clk_n` is low, so that data and clock reach the edge detector on the same cycle. The stimulus holds each serial clock phase for eight system cycles and changes data only in the low phase. It also waits several cycles after every mode or power-down change, so the synchronisers settle before any indication is sampled.

// File: rtl/cid_pkg.sv
`timescale 1ns/1ps
// Shared types for the caller-ID host interface.
// Assumes: nothing beyond IEEE 1800-2017.
package cid_pkg;

    // Operating view of the block, decoded from pins and control register
    typedef enum logic [1:0] {
        MD_PWRDN = 2'd0,
        MD_CAS   = 2'd1,
        MD_CPM   = 2'd2,
        MD_FSK   = 2'd3
    } cid_mode_e;

endpackage

// File: rtl/cid_sync.sv
`timescale 1ns/1ps
// Multi-bit flop-chain synchroniser with a per-bit reset value.
// Assumes: each bit is an independent level; no bus coherence implied.
module cid_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg_q [STAGES];

    // Shift asynchronous levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/cid_ctrl_port.sv
`timescale 1ns/1ps
// Serial control-register write port: MSB-first shift on serial clock
// rising edges, commit after CTRL_W bits. Writes need an arming low on
// the write-mode level first, which also realigns the bit counter.
// Assumes: rise is a one-cycle pulse; din is aligned with it.
module cid_ctrl_port #(
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mode,
    input  logic              rise,
    input  logic              din,
    output logic [CTRL_W-1:0] ctrl,
    output logic              armed
);

    localparam int CNT_W = (CTRL_W > 1) ? $clog2(CTRL_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CTRL_W - 1);

    logic [CTRL_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CTRL_W-1:0] next_sh;

    // Shift register contents after taking in the current bit
    always_comb next_sh = {sh_q[CTRL_W-2:0], din};

    // Arm, count, shift and commit control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
            ctrl  <= '0;
            armed <= 1'b0;
        end else if (!wr_mode) begin
            cnt_q <= '0;
            armed <= 1'b1;
        end else if (rise && armed) begin
            sh_q <= next_sh;
            if (cnt_q == LAST) begin
                ctrl  <= next_sh;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cid_rx_readout.sv
`timescale 1ns/1ps
// Received-byte readout: holds the latest byte, flags it ready, presents
// one bit per serial clock falling edge MSB first, and drops the ready
// flag on the first rising edge (first bit read).
// Assumes: enable is high only in FSK mode; fall/rise are single pulses.
module cid_rx_readout #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic              fall,
    input  logic              rise,
    output logic              ready,
    output logic              bit_out
);

    logic [DATA_W-1:0] sh_q;

    // Load, present and acknowledge received bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '1;
            ready   <= 1'b0;
            bit_out <= 1'b1;
        end else if (!enable) begin
            ready   <= 1'b0;
            bit_out <= 1'b1;
        end else if (load) begin
            sh_q    <= data;
            ready   <= 1'b1;
            bit_out <= 1'b1;
        end else begin
            if (rise) ready <= 1'b0;
            if (fall) begin
                bit_out <= sh_q[DATA_W-1];
                sh_q    <= {sh_q[DATA_W-2:0], 1'b1};
            end
        end
    end

endmodule

// File: rtl/cid_out_sel.sv
`timescale 1ns/1ps
// Mode-dependent steering of the three indications and the read line,
// registered for glitch-free pins.
// Assumes: all inputs synchronous to clk.
module cid_out_sel
    import cid_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cid_mode_e mode,
    input  logic      wake,
    input  logic      cas_tone,
    input  logic      cpm_tone,
    input  logic      fsk_energy,
    input  logic      ring_det,
    input  logic      line_rev,
    input  logic      on_hook,
    input  logic      ready,
    input  logic      rd_bit,
    output logic      irq_n,
    output logic      det_n,
    output logic      ring_hook_n,
    output logic      ser_dout
);

    logic irq_d, det_d, rh_d, dout_d;

    // Select next active-low indication levels by mode
    always_comb begin
        rh_d   = wake ? on_hook : ~ring_det;
        dout_d = 1'b1;
        unique case (mode)
            MD_PWRDN: begin
                irq_d = ~(ring_det | line_rev);
                det_d = wake ? ~(ring_det | fsk_energy) : ~(ring_det | line_rev);
            end
            MD_CAS: begin
                irq_d = ~cas_tone;
                det_d = ~cas_tone;
            end
            MD_CPM: begin
                irq_d = ~cpm_tone;
                det_d = ~cpm_tone;
            end
            default: begin
                irq_d  = ~ready;
                det_d  = ~fsk_energy;
                dout_d = rd_bit;
            end
        endcase
    end

    // Register pin levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n       <= 1'b1;
            det_n       <= 1'b1;
            ring_hook_n <= 1'b1;
            ser_dout    <= 1'b1;
        end else begin
            irq_n       <= irq_d;
            det_n       <= det_d;
            ring_hook_n <= rh_d;
            ser_dout    <= dout_d;
        end
    end

endmodule

// File: rtl/cid_host_if.sv
`timescale 1ns/1ps
// Caller-ID receiver host interface top: synchronises pins, decodes the
// operating mode, runs the serial write and readout ports and steers the
// active-low indications.
// Assumes: detector flags and pwr_down are synchronous to clk.
module cid_host_if
    import cid_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CTRL_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CPM_BIT     = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_cas,
    input  logic              mode_wake,
    input  logic              pwr_down,
    input  logic              ser_clk_n,
    input  logic              ser_din,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_valid,
    input  logic              cas_tone,
    input  logic              cpm_tone,
    input  logic              fsk_energy,
    input  logic              ring_det,
    input  logic              line_rev,
    input  logic              on_hook,
    output logic              ser_dout,
    output logic              irq_n,
    output logic              det_n,
    output logic              ring_hook_n
);

    localparam int         PIN_W   = 4;
    localparam logic [3:0] PIN_RST = 4'b1010;

    logic [PIN_W-1:0]  pins_s;
    logic              cas_s, wake_s, sclk_s, din_s;
    logic              sclk_d;
    logic              sclk_rise, sclk_fall;
    logic [CTRL_W-1:0] ctrl;
    logic              armed;
    cid_mode_e         mode;
    logic              ready, rd_bit;

    cid_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({mode_cas, mode_wake, ser_clk_n, ser_din}),
        .q    (pins_s)
    );

    assign {cas_s, wake_s, sclk_s, din_s} = pins_s;

    // Delay synchronised serial clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b1;
        else        sclk_d <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;

    // Decode operating mode from power-down, mode pin and CPM select bit
    always_comb begin
        if (pwr_down)           mode = MD_PWRDN;
        else if (cas_s)         mode = MD_CAS;
        else if (ctrl[CPM_BIT]) mode = MD_CPM;
        else                    mode = MD_FSK;
    end

    cid_ctrl_port #(.CTRL_W(CTRL_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_mode(cas_s),
        .rise   (sclk_rise),
        .din    (din_s),
        .ctrl   (ctrl),
        .armed  (armed)
    );

    cid_rx_readout #(.DATA_W(DATA_W)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (mode == MD_FSK),
        .load   (rx_valid),
        .data   (rx_data),
        .fall   (sclk_fall),
        .rise   (sclk_rise),
        .ready  (ready),
        .bit_out(rd_bit)
    );

    cid_out_sel u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .wake       (wake_s),
        .cas_tone   (cas_tone),
        .cpm_tone   (cpm_tone),
        .fsk_energy (fsk_energy),
        .ring_det   (ring_det),
        .line_rev   (line_rev),
        .on_hook    (on_hook),
        .ready      (ready),
        .rd_bit     (rd_bit),
        .irq_n      (irq_n),
        .det_n      (det_n),
        .ring_hook_n(ring_hook_n),
        .ser_dout   (ser_dout)
    );

endmodule

// File: rtl/cid_host_if_chk.sv
`timescale 1ns/1ps
// Property checker for cid_host_if, attached by bind.
// Assumes: detector flags and pwr_down synchronous to clk.
module cid_host_if_chk #(
    parameter int CTRL_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_down,
    input logic              ring_det,
    input logic              line_rev,
    input logic              on_hook,
    input logic              cas_tone,
    input logic              irq_n,
    input logic              ser_dout,
    input logic              ring_hook_n,
    input logic              cas_s,
    input logic              wake_s,
    input logic              armed,
    input logic [CTRL_W-1:0] ctrl
);

    // R2: control register cannot change before arming
    a_r2_unarmed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> $stable(ctrl));

    // R6: read line idle high in power-down
    a_r6_dout_pd: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> ser_dout);

    // R6: read line idle high in CAS mode
    a_r6_dout_cas: assert property (@(posedge clk) disable iff (!rst_n)
        cas_s |=> ser_dout);

    // R7: CAS tone drives interrupt
    a_r7_cas_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_s && !pwr_down && cas_tone) |=> !irq_n);

    // R8: ring or reversal wakes host in power-down
    a_r8_pd_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && (ring_det || line_rev)) |=> !irq_n);

    // R11: hook state passed in wake variant
    a_r11_hook: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_s && on_hook) |=> ring_hook_n);

    // R11: ring passed inverted otherwise
    a_r11_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_s && ring_det) |=> !ring_hook_n);

endmodule

bind cid_host_if cid_host_if_chk #(.CTRL_W(CTRL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_down   (pwr_down),
    .ring_det   (ring_det),
    .line_rev   (line_rev),
    .on_hook    (on_hook),
    .cas_tone   (cas_tone),
    .irq_n      (irq_n),
    .ser_dout   (ser_dout),
    .ring_hook_n(ring_hook_n),
    .cas_s      (cas_s),
    .wake_s     (wake_s),
    .armed      (armed),
    .ctrl       (ctrl)
);

// File: tb/cid_host_if_tb.sv
`timescale 1ns/1ps
module cid_host_if_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_cas = 1'b1, mode_wake = 1'b0, pwr_down = 1'b0;
    logic       ser_clk_n = 1'b1, ser_din = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_valid = 1'b0;
    logic       cas_tone = 1'b0, cpm_tone = 1'b0, fsk_energy = 1'b0;
    logic       ring_det = 1'b0, line_rev = 1'b0, on_hook = 1'b0;
    logic       ser_dout, irq_n, det_n, ring_hook_n;

    int         checks = 0;
    int         errors = 0;
    logic [7:0] exp_q[$];
    logic [7:0] got_byte;
    event       byte_done;

    always #10 clk = ~clk;

    cid_host_if u_dut (
        .clk(clk), .rst_n(rst_n), .mode_cas(mode_cas), .mode_wake(mode_wake),
        .pwr_down(pwr_down), .ser_clk_n(ser_clk_n), .ser_din(ser_din),
        .rx_data(rx_data), .rx_valid(rx_valid), .cas_tone(cas_tone),
        .cpm_tone(cpm_tone), .fsk_energy(fsk_energy), .ring_det(ring_det),
        .line_rev(line_rev), .on_hook(on_hook), .ser_dout(ser_dout),
        .irq_n(irq_n), .det_n(det_n), .ring_hook_n(ring_hook_n)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic host_bit(input logic d);
        ser_din = d; ser_clk_n = 1'b0; wait_cyc(8);
        ser_clk_n = 1'b1; wait_cyc(8);
    endtask

    task automatic host_write(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) host_bit(v[i]);
    endtask

    task automatic set_cas(input logic v);
        mode_cas = v; wait_cyc(6);
    endtask

    // Driver: deliver a byte and push the expected readout
    task automatic send_byte(input logic [7:0] v);
        rx_data = v; rx_valid = 1'b1; wait_cyc(1);
        rx_valid = 1'b0; exp_q.push_back(v); wait_cyc(4);
    endtask

    // Host read of one byte; R4 irq release after first bit
    task automatic host_read;
        logic [7:0] b;
        for (int i = 7; i >= 0; i--) begin
            ser_clk_n = 1'b0; wait_cyc(8);
            b[i] = ser_dout;
            ser_clk_n = 1'b1; wait_cyc(8);
            if (i == 7) chk("R4 irq high after first bit", irq_n, 1'b1);
        end
        got_byte = b;
        -> byte_done;
        wait_cyc(1);
    endtask

    // Monitor: compare each read byte with the scoreboard (R5)
    initial begin
        forever begin
            @(byte_done);
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5 actual=%h expected=<none>", got_byte);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (got_byte !== e) begin
                    errors++;
                    $display("FAIL R5 actual=%h expected=%h", got_byte, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(5);
        // R1 reset levels
        chk("R1 irq_n in reset", irq_n, 1'b1);
        chk("R1 det_n in reset", det_n, 1'b1);
        chk("R1 ring_hook_n in reset", ring_hook_n, 1'b1);
        chk("R1 ser_dout in reset", ser_dout, 1'b1);
        rst_n = 1'b1; wait_cyc(6);
        chk("R6 dout high in CAS", ser_dout, 1'b1);

        // R2 write before arming is ignored: CPM bit stays 0
        host_write(8'h01);
        set_cas(1'b0);
        cpm_tone = 1'b1; wait_cyc(4);
        chk("R2 unarmed write ignored", irq_n, 1'b1);
        cpm_tone = 1'b0;

        // R3 armed write sets CPM select (bit 0)
        set_cas(1'b1); host_write(8'h01); set_cas(1'b0);
        cpm_tone = 1'b1; wait_cyc(4);
        chk("R3 CPM selected, R7 irq on cpm", irq_n, 1'b0);
        chk("R10 det on cpm", det_n, 1'b0);
        chk("R6 dout high in CPM", ser_dout, 1'b1);
        cpm_tone = 1'b0; wait_cyc(4);
        chk("R7 irq follows cpm off", irq_n, 1'b1);

        // R2 partial write discarded by mode_cas low
        set_cas(1'b1); host_write(8'h00);
        for (int i = 0; i < 4; i++) host_bit(1'b1);
        set_cas(1'b0); set_cas(1'b1);
        host_write(8'h01); set_cas(1'b0);
        cpm_tone = 1'b1; wait_cyc(4);
        chk("R2 realigned write", irq_n, 1'b0);
        cpm_tone = 1'b0;

        // R7 CAS tone
        set_cas(1'b1);
        cas_tone = 1'b1; wait_cyc(4);
        chk("R7 irq on cas", irq_n, 1'b0);
        chk("R10 det on cas", det_n, 1'b0);
        chk("R6 dout high with cas", ser_dout, 1'b1);
        cas_tone = 1'b0; wait_cyc(4);
        chk("R7 irq follows cas off", irq_n, 1'b1);

        // R12 byte outside FSK ignored; select FSK
        rx_data = 8'hA5; rx_valid = 1'b1; wait_cyc(1); rx_valid = 1'b0;
        host_write(8'h00); set_cas(1'b0); wait_cyc(4);
        chk("R12 no irq from stale byte", irq_n, 1'b1);

        // R4/R5 FSK readout
        send_byte(8'hA5);
        chk("R4 irq on byte ready", irq_n, 1'b0);
        host_read();
        send_byte(8'h3C);
        chk("R4 irq on second byte", irq_n, 1'b0);
        host_read();
        fsk_energy = 1'b1; wait_cyc(4);
        chk("R10 det on fsk energy", det_n, 1'b0);
        fsk_energy = 1'b0; wait_cyc(4);

        // R11 ring/hook
        ring_det = 1'b1; wait_cyc(4);
        chk("R11 ring shown", ring_hook_n, 1'b0);
        ring_det = 1'b0; mode_wake = 1'b1; on_hook = 1'b1; wait_cyc(6);
        chk("R11 on-hook high", ring_hook_n, 1'b1);
        on_hook = 1'b0; wait_cyc(4);
        chk("R11 off-hook low", ring_hook_n, 1'b0);

        // R8/R9 power-down
        mode_wake = 1'b0; pwr_down = 1'b1; wait_cyc(6);
        chk("R8 pd idle irq", irq_n, 1'b1);
        chk("R6 dout high in pd", ser_dout, 1'b1);
        line_rev = 1'b1; wait_cyc(4);
        chk("R8 pd irq on reversal", irq_n, 1'b0);
        chk("R9 pd det on reversal", det_n, 1'b0);
        mode_wake = 1'b1; wait_cyc(6);
        chk("R9 wake det ignores reversal", det_n, 1'b1);
        fsk_energy = 1'b1; wait_cyc(4);
        chk("R9 wake det on energy", det_n, 1'b0);
        line_rev = 1'b0; fsk_energy = 1'b0; ring_det = 1'b1; wait_cyc(4);
        chk("R8 pd irq on ring", irq_n, 1'b0);
        ring_det = 1'b0; pwr_down = 1'b0; mode_wake = 1'b0; wait_cyc(6);

        // R1 reset clears the control register
        set_cas(1'b1); host_write(8'h01); set_cas(1'b0);
        rst_n = 1'b0; wait_cyc(3); rst_n = 1'b1; wait_cyc(6);
        cpm_tone = 1'b1; wait_cyc(4);
        chk("R1 CPM bit cleared by reset", irq_n, 1'b1);
        cpm_tone = 1'b0;

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R5 actual=%0d expected=0 unread bytes", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule